// File: doc/BRIEF.md
# Two-Level Conform-Aware Traffic Policer

This block meters packets in two stages. A bank of per-class child meters, one per traffic class, colours each arriving packet green, yellow or red from its own token buckets. A single aggregate parent meter then decides whether the packet still fits the total budget. With the conform-aware option set, the parent always admits packets that were green at their child meter, while still charging them to the shared budget. Only out-of-profile traffic (child yellow) competes for what is left. With the option clear, the parent drops any packet that lacks parent tokens, whatever its child colour.

A packet event carries a class index and a byte length. One cycle later the block reports the final colour and the action chosen for that colour: transmit, drop, or transmit with two remark codes. Token refills happen on a `tick` strobe. Each rate is given in bytes per tick, so with a 1 ms tick one rate unit is 8 kbps. The block also compares the configured rates and raises a configuration-error flag when the parent rate does not exceed the sum of the child committed rates.

Top module: `hier_policer`

## Requirements
- R1: While `rst` is high and in the cycle after it, `res_valid` is 0. Reset loads every bucket with its configured burst size: the committed bucket with `child_cbs`, the second bucket with `child_pbs`, and the parent with `par_burst`.
- R2: A class in mode 0 (single-rate two-colour) is green when its committed bucket holds at least `pkt_len`, and then that bucket is debited by the length. Otherwise the packet is red.
- R3: A class in mode 1 (single-rate three-colour) is green if the committed bucket covers the length, and debits it. Otherwise it is yellow if the excess bucket (burst `child_pbs`) covers the length, and debits that bucket. Otherwise it is red. On a tick the committed bucket gains `child_cir`, and whatever exceeds `child_cbs` spills into the excess bucket, which saturates at `child_pbs`.
- R4: A class in mode 2 or 3 (two-rate three-colour) is red when the peak bucket is short of the length. It is yellow when only the committed bucket is short, and then debits the peak bucket. Otherwise it is green and debits both buckets. The buckets refill by `child_cir` and `child_pir` and saturate at `child_cbs` and `child_pbs`.
- R5: On a `tick`, every bucket gains its rate and never holds more than its burst size. A packet exactly as long as a full bucket conforms, and the next 1-byte packet does not.
- R6: With `conform_aware` = 1, a child-green packet is always passed as green and is charged to the parent. The parent level may go negative but saturates at `-par_burst`. A child-yellow packet passes as yellow only when the parent level is at least its length, and is otherwise red.
- R7: With `conform_aware` = 0, a child green or yellow packet keeps its colour and debits the parent when the parent level is at least its length. Otherwise it is red and the parent is not charged.
- R8: A child-red packet is finally red and charges no parent tokens.
- R9: `act_cfg` holds one field per colour, at bit offset colour×(2+2×MARK_W), where green=0, yellow=1 and red=2. Each field is laid out as {mark_b, mark_a, kind[1:0]}. Kind 0 gives action 0 (transmit), kind 1 or 3 gives action 1 (drop), and kind 2 gives action 2 (transmit with remark) with `res_mark_a`/`res_mark_b` set from the field. The marks are 0 for any other action.
- R10: `cfg_err` is 1 when `par_rate` is less than or equal to the sum of all `child_cir`, and 0 otherwise. It is registered one cycle after the configuration.
- R11: A packet presented in cycle N gives `res_valid` = 1 with its result in cycle N+1. `res_valid` is 0 in a cycle that follows no packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Refill strobe |
| pkt_valid | input | 1 | Packet event |
| pkt_class | input | CLS_W | Traffic class index |
| pkt_len | input | LEN_W | Packet length in bytes |
| child_mode | input | 2×NUM_CLASS | Per-class meter mode |
| child_cir | input | NUM_CLASS×RATE_W | Per-class committed rate, bytes per tick |
| child_pir | input | NUM_CLASS×RATE_W | Per-class peak rate, bytes per tick |
| child_cbs | input | NUM_CLASS×TOK_W | Per-class committed burst |
| child_pbs | input | NUM_CLASS×TOK_W | Per-class peak or excess burst |
| par_rate | input | RATE_W | Parent rate, bytes per tick |
| par_burst | input | TOK_W | Parent burst |
| conform_aware | input | 1 | Protect child-green traffic at the parent |
| act_cfg | input | 3×(2+2×MARK_W) | Per-colour action and remark codes |
| res_valid | output | 1 | Result valid |
| res_color | output | 2 | Final colour: 0 green, 1 yellow, 2 red |
| res_action | output | 2 | 0 transmit, 1 drop, 2 transmit with remark |
| res_mark_a | output | MARK_W | First remark code |
| res_mark_b | output | MARK_W | Second remark code |
| cfg_err | output | 1 | Parent rate not above the child committed sum |

## Verification
Each packet result is due exactly one clock edge after the edge that samples `pkt_valid`. The bench drives every input just after a rising edge and reads colour, action and marks just after the following rising edge, when the output register has settled. `cfg_err` depends only on static configuration and is read a few cycles after reset. Ticks are never issued in the same cycle as a packet, so the bench model can apply refills and debits in a fixed order.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic [1:0] {CLR_GREEN = 2'd0, CLR_YELLOW = 2'd1, CLR_RED = 2'd2} color_e;
  typedef enum logic [1:0] {MODE_SR2C = 2'd0, MODE_SR3C = 2'd1, MODE_TR3C = 2'd2} mode_e;
  typedef enum logic [1:0] {ACT_XMIT = 2'd0, ACT_DROP = 2'd1, ACT_MARK = 2'd2} act_e;
endpackage

// File: rtl/hp_child_meter.sv
module hp_child_meter #(
  parameter int LEN_W  = 11,
  parameter int RATE_W = 14,
  parameter int TOK_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              hit,
  input  logic [LEN_W-1:0]  len,
  input  logic [1:0]        mode,
  input  logic [RATE_W-1:0] cir,
  input  logic [RATE_W-1:0] pir,
  input  logic [TOK_W-1:0]  cbs,
  input  logic [TOK_W-1:0]  pbs,
  output logic [1:0]        color
);
  import hp_pkg::*;
  localparam int WW = TOK_W + 2;

  logic [TOK_W-1:0] cb, pb;
  logic [WW-1:0]    len_w, cir_w, pir_w, cbs_w, pbs_w;
  logic [WW-1:0]    c_sum, p_sum, ovf, p_add;
  logic             c_ok, p_ok, dc, dp;
  color_e           col;

  assign len_w = {{(WW-LEN_W){1'b0}}, len};
  assign cir_w = {{(WW-RATE_W){1'b0}}, cir};
  assign pir_w = {{(WW-RATE_W){1'b0}}, pir};
  assign cbs_w = {2'b00, cbs};
  assign pbs_w = {2'b00, pbs};
  assign c_ok  = {2'b00, cb} >= len_w;
  assign p_ok  = {2'b00, pb} >= len_w;
  assign color = col;

  always_comb begin
    col = CLR_RED;
    dc  = 1'b0;
    dp  = 1'b0;
    case (mode)
      MODE_SR2C: begin
        if (c_ok) begin col = CLR_GREEN; dc = 1'b1; end
      end
      MODE_SR3C: begin
        if (c_ok) begin col = CLR_GREEN; dc = 1'b1; end
        else if (p_ok) begin col = CLR_YELLOW; dp = 1'b1; end
      end
      default: begin
        if (!p_ok) col = CLR_RED;
        else if (!c_ok) begin col = CLR_YELLOW; dp = 1'b1; end
        else begin col = CLR_GREEN; dc = 1'b1; dp = 1'b1; end
      end
    endcase
  end

  always_comb begin
    c_sum = {2'b00, cb} - ((hit && dc) ? len_w : '0) + (tick ? cir_w : '0);
    ovf   = (c_sum > cbs_w) ? (c_sum - cbs_w) : '0;
    p_add = (mode == MODE_SR3C) ? ovf : (tick ? pir_w : '0);
    p_sum = {2'b00, pb} - ((hit && dp) ? len_w : '0) + p_add;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cb <= cbs;
      pb <= pbs;
    end else begin
      cb <= (c_sum > cbs_w) ? cbs : c_sum[TOK_W-1:0];
      pb <= (p_sum > pbs_w) ? pbs : p_sum[TOK_W-1:0];
    end
  end
endmodule

// File: rtl/hp_parent_meter.sv
module hp_parent_meter #(
  parameter int LEN_W  = 11,
  parameter int RATE_W = 14,
  parameter int TOK_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic                    hit,
  input  logic                    green,
  input  logic                    aware,
  input  logic [LEN_W-1:0]        len,
  input  logic [RATE_W-1:0]       rate,
  input  logic [TOK_W-1:0]        burst,
  output logic                    pass,
  output logic signed [TOK_W+1:0] level
);
  localparam int SW = TOK_W + 2;

  logic signed [SW-1:0] len_s, rate_s, burst_s, deb, add, nxt;

  assign len_s   = $signed({{(SW-LEN_W){1'b0}}, len});
  assign rate_s  = $signed({{(SW-RATE_W){1'b0}}, rate});
  assign burst_s = $signed({2'b00, burst});
  assign pass    = (level >= len_s) || (aware && green);

  always_comb begin
    deb = (hit && pass) ? len_s : '0;
    add = tick ? rate_s : '0;
    nxt = level - deb + add;
  end

  always_ff @(posedge clk) begin
    if (rst)                level <= burst_s;
    else if (nxt > burst_s) level <= burst_s;
    else if (nxt < -burst_s) level <= -burst_s;
    else                    level <= nxt;
  end
endmodule

// File: rtl/hp_action_map.sv
module hp_action_map #(
  parameter int MARK_W = 3,
  localparam int AW    = 2 + 2 * MARK_W
) (
  input  logic [1:0]        color,
  input  logic [3*AW-1:0]   cfg,
  output logic [1:0]        action,
  output logic [MARK_W-1:0] mark_a,
  output logic [MARK_W-1:0] mark_b
);
  import hp_pkg::*;
  logic [AW-1:0] fld;

  always_comb begin
    fld = '0;
    for (int c = 0; c < 3; c++)
      if (color == 2'(c)) fld = cfg[c*AW +: AW];
    mark_a = '0;
    mark_b = '0;
    case (fld[1:0])
      2'd0: action = ACT_XMIT;
      2'd2: begin
        action = ACT_MARK;
        mark_a = fld[2 +: MARK_W];
        mark_b = fld[2+MARK_W +: MARK_W];
      end
      default: action = ACT_DROP;
    endcase
  end
endmodule

// File: rtl/hier_policer.sv
module hier_policer #(
  parameter int NUM_CLASS = 4,
  parameter int LEN_W     = 11,
  parameter int RATE_W    = 14,
  parameter int TOK_W     = 16,
  parameter int MARK_W    = 3,
  localparam int CLS_W    = (NUM_CLASS > 1) ? $clog2(NUM_CLASS) : 1,
  localparam int AW       = 2 + 2 * MARK_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tick,
  input  logic                        pkt_valid,
  input  logic [CLS_W-1:0]            pkt_class,
  input  logic [LEN_W-1:0]            pkt_len,
  input  logic [2*NUM_CLASS-1:0]      child_mode,
  input  logic [NUM_CLASS*RATE_W-1:0] child_cir,
  input  logic [NUM_CLASS*RATE_W-1:0] child_pir,
  input  logic [NUM_CLASS*TOK_W-1:0]  child_cbs,
  input  logic [NUM_CLASS*TOK_W-1:0]  child_pbs,
  input  logic [RATE_W-1:0]           par_rate,
  input  logic [TOK_W-1:0]            par_burst,
  input  logic                        conform_aware,
  input  logic [3*AW-1:0]             act_cfg,
  output logic                        res_valid,
  output logic [1:0]                  res_color,
  output logic [1:0]                  res_action,
  output logic [MARK_W-1:0]           res_mark_a,
  output logic [MARK_W-1:0]           res_mark_b,
  output logic                        cfg_err
);
  import hp_pkg::*;
  localparam int SUM_W = RATE_W + CLS_W + 1;

  logic [1:0]              kid_color [NUM_CLASS];
  logic [1:0]              sel_color, fin_color, act;
  logic                    par_pass;
  logic signed [TOK_W+1:0] par_level;
  logic [MARK_W-1:0]       ma, mb;
  logic [SUM_W-1:0]        cir_sum;

  for (genvar i = 0; i < NUM_CLASS; i++) begin : g_child
    hp_child_meter #(.LEN_W(LEN_W), .RATE_W(RATE_W), .TOK_W(TOK_W)) u_meter (
      .clk(clk), .rst(rst), .tick(tick),
      .hit(pkt_valid && (pkt_class == CLS_W'(i))),
      .len(pkt_len),
      .mode(child_mode[2*i +: 2]),
      .cir(child_cir[i*RATE_W +: RATE_W]),
      .pir(child_pir[i*RATE_W +: RATE_W]),
      .cbs(child_cbs[i*TOK_W +: TOK_W]),
      .pbs(child_pbs[i*TOK_W +: TOK_W]),
      .color(kid_color[i])
    );
  end

  always_comb begin
    sel_color = CLR_RED;
    for (int i = 0; i < NUM_CLASS; i++)
      if (pkt_class == CLS_W'(i)) sel_color = kid_color[i];
  end

  hp_parent_meter #(.LEN_W(LEN_W), .RATE_W(RATE_W), .TOK_W(TOK_W)) u_parent (
    .clk(clk), .rst(rst), .tick(tick),
    .hit(pkt_valid && (sel_color != CLR_RED)),
    .green(sel_color == CLR_GREEN),
    .aware(conform_aware),
    .len(pkt_len), .rate(par_rate), .burst(par_burst),
    .pass(par_pass), .level(par_level)
  );

  assign fin_color = ((sel_color != CLR_RED) && par_pass) ? sel_color : CLR_RED;

  hp_action_map #(.MARK_W(MARK_W)) u_map (
    .color(fin_color), .cfg(act_cfg), .action(act), .mark_a(ma), .mark_b(mb)
  );

  always_comb begin
    cir_sum = '0;
    for (int i = 0; i < NUM_CLASS; i++)
      cir_sum = cir_sum + SUM_W'(child_cir[i*RATE_W +: RATE_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_color  <= CLR_GREEN;
      res_action <= ACT_XMIT;
      res_mark_a <= '0;
      res_mark_b <= '0;
      cfg_err    <= 1'b0;
    end else begin
      res_valid <= pkt_valid;
      cfg_err   <= SUM_W'(par_rate) <= cir_sum;
      if (pkt_valid) begin
        res_color  <= fin_color;
        res_action <= act;
        res_mark_a <= ma;
        res_mark_b <= mb;
      end
    end
  end
endmodule

// File: rtl/hier_policer_chk.sv
module hier_policer_chk #(
  parameter int TOK_W  = 16,
  parameter int MARK_W = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    pkt_valid,
  input logic                    conform_aware,
  input logic [1:0]              sel_color,
  input logic                    res_valid,
  input logic [1:0]              res_color,
  input logic [1:0]              res_action,
  input logic [MARK_W-1:0]       res_mark_a,
  input logic [MARK_W-1:0]       res_mark_b,
  input logic signed [TOK_W+1:0] par_level,
  input logic [TOK_W-1:0]        par_burst
);
  assert_result_follows_R11: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |=> res_valid);
  assert_no_spurious_R11: assert property (@(posedge clk) disable iff (rst)
    !pkt_valid |=> !res_valid);
  assert_green_protected_R6: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && conform_aware && sel_color == 2'd0) |=> (res_color == 2'd0));
  assert_child_red_final_R8: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && sel_color == 2'd2) |=> (res_color == 2'd2));
  assert_marks_only_on_remark_R9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_action != 2'd2) |-> (res_mark_a == '0 && res_mark_b == '0));
  assert_parent_bounded_R6: assert property (@(posedge clk) disable iff (rst)
    (par_level <= $signed({2'b00, par_burst})) && (par_level >= -$signed({2'b00, par_burst})));
endmodule

bind hier_policer hier_policer_chk #(.TOK_W(TOK_W), .MARK_W(MARK_W)) u_chk (
  .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .conform_aware(conform_aware),
  .sel_color(sel_color), .res_valid(res_valid), .res_color(res_color),
  .res_action(res_action), .res_mark_a(res_mark_a), .res_mark_b(res_mark_b),
  .par_level(par_level), .par_burst(par_burst)
);

// File: tb/hier_policer_tb.sv
module hier_policer_tb;
  localparam int NC = 4, LEN_W = 11, RATE_W = 14, TOK_W = 16, MARK_W = 3;
  localparam int AW = 2 + 2 * MARK_W;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, pkt_valid = 1'b0, conform_aware = 1'b0;
  logic [1:0] pkt_class = '0;
  logic [LEN_W-1:0] pkt_len = '0;
  logic [2*NC-1:0] child_mode;
  logic [NC*RATE_W-1:0] child_cir, child_pir;
  logic [NC*TOK_W-1:0] child_cbs, child_pbs;
  logic [RATE_W-1:0] par_rate;
  logic [TOK_W-1:0] par_burst;
  logic [3*AW-1:0] act_cfg;
  logic res_valid, cfg_err;
  logic [1:0] res_color, res_action;
  logic [MARK_W-1:0] res_mark_a, res_mark_b;

  hier_policer #(.NUM_CLASS(NC), .LEN_W(LEN_W), .RATE_W(RATE_W), .TOK_W(TOK_W), .MARK_W(MARK_W)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .pkt_valid(pkt_valid), .pkt_class(pkt_class),
    .pkt_len(pkt_len), .child_mode(child_mode), .child_cir(child_cir), .child_pir(child_pir),
    .child_cbs(child_cbs), .child_pbs(child_pbs), .par_rate(par_rate), .par_burst(par_burst),
    .conform_aware(conform_aware), .act_cfg(act_cfg), .res_valid(res_valid),
    .res_color(res_color), .res_action(res_action), .res_mark_a(res_mark_a),
    .res_mark_b(res_mark_b), .cfg_err(cfg_err)
  );

  always #2 clk = ~clk;

  int vectors = 0, fails = 0;
  bit done = 1'b0;
  int cmode[NC], ccir[NC], cpir[NC], ccbs[NC], cpbs[NC];
  int prate, pburst, aware;
  int akind[3], ama[3], amb[3];
  int cb[NC], pb[NC], plv;

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply_cfg();
    for (int i = 0; i < NC; i++) begin
      child_mode[2*i +: 2] = 2'(cmode[i]);
      child_cir[i*RATE_W +: RATE_W] = RATE_W'(ccir[i]);
      child_pir[i*RATE_W +: RATE_W] = RATE_W'(cpir[i]);
      child_cbs[i*TOK_W +: TOK_W] = TOK_W'(ccbs[i]);
      child_pbs[i*TOK_W +: TOK_W] = TOK_W'(cpbs[i]);
    end
    par_rate = RATE_W'(prate);
    par_burst = TOK_W'(pburst);
    conform_aware = aware[0];
    for (int c = 0; c < 3; c++)
      act_cfg[c*AW +: AW] = {MARK_W'(amb[c]), MARK_W'(ama[c]), 2'(akind[c])};
  endtask

  task automatic do_reset();
    apply_cfg();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid in reset", int'(res_valid), 0);
    rst = 1'b0;
    for (int i = 0; i < NC; i++) begin cb[i] = ccbs[i]; pb[i] = cpbs[i]; end
    plv = pburst;
    @(posedge clk); #1;
    check("R1 valid after reset", int'(res_valid), 0);
  endtask

  task automatic do_tick();
    tick = 1'b1;
    @(posedge clk); #1;
    tick = 1'b0;
    check("R11 idle after tick", int'(res_valid), 0);
    for (int i = 0; i < NC; i++) begin
      int c, p, o;
      if (cmode[i] == 1) begin
        c = cb[i] + ccir[i];
        o = (c > ccbs[i]) ? c - ccbs[i] : 0;
        if (c > ccbs[i]) c = ccbs[i];
        p = pb[i] + o;
      end else begin
        c = cb[i] + ccir[i];
        if (c > ccbs[i]) c = ccbs[i];
        p = pb[i] + cpir[i];
      end
      cb[i] = c;
      pb[i] = (p > cpbs[i]) ? cpbs[i] : p;
    end
    plv = plv + prate;
    if (plv > pburst) plv = pburst;
  endtask

  task automatic send(input int cls, input int len, input string extra);
    int col, kid, ea, ema, emb;
    string mtag, ptag;
    col = 2;
    if (cmode[cls] == 0) begin
      mtag = "R2";
      if (cb[cls] >= len) begin col = 0; cb[cls] -= len; end
    end else if (cmode[cls] == 1) begin
      mtag = "R3";
      if (cb[cls] >= len) begin col = 0; cb[cls] -= len; end
      else if (pb[cls] >= len) begin col = 1; pb[cls] -= len; end
    end else begin
      mtag = "R4";
      if (pb[cls] < len) col = 2;
      else if (cb[cls] < len) begin col = 1; pb[cls] -= len; end
      else begin col = 0; cb[cls] -= len; pb[cls] -= len; end
    end
    kid = col;
    if (kid == 2) ptag = "R8";
    else begin
      ptag = (aware != 0) ? "R6" : "R7";
      if (plv >= len || (aware != 0 && kid == 0)) begin
        plv -= len;
        if (plv < -pburst) plv = -pburst;
      end else col = 2;
    end
    ea = (akind[col] == 0) ? 0 : (akind[col] == 2) ? 2 : 1;
    ema = (ea == 2) ? ama[col] : 0;
    emb = (ea == 2) ? amb[col] : 0;
    pkt_valid = 1'b1;
    pkt_class = 2'(cls);
    pkt_len = LEN_W'(len);
    @(posedge clk); #1;
    pkt_valid = 1'b0;
    check({"R11 valid ", extra}, int'(res_valid), 1);
    check({ptag, "/", mtag, " colour ", extra}, int'(res_color), col);
    check({"R9 action ", extra}, int'(res_action), ea);
    check({"R9 marks ", extra}, int'({res_mark_b, res_mark_a}), (emb << MARK_W) | ema);
  endtask

  task automatic base_cfg(input int aw, input int pr);
    cmode = '{0, 1, 2, 3};
    ccir = '{40, 30, 20, 10};
    cpir = '{55, 0, 60, 30};
    ccbs = '{200, 150, 100, 80};
    cpbs = '{250, 300, 300, 200};
    prate = pr; pburst = 400; aware = aw;
  endtask

  task automatic sweep(input int n, input int seed);
    int s;
    s = seed;
    for (int k = 0; k < n; k++) begin
      int cls, len;
      cls = $urandom(s) % NC; s = s + 7;
      len = 1 + ($urandom(s) % 140); s = s + 13;
      send(cls, len, "sweep");
      if (k % 3 == 2) do_tick();
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 0 expected 1 (run finished)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // scenario 1: conform-aware, marks on yellow, drop on red
    base_cfg(1, 120);
    akind = '{0, 2, 1}; ama = '{0, 5, 0}; amb = '{0, 3, 0};
    do_reset();
    repeat (2) @(posedge clk); #1;
    check("R10 cfg ok", int'(cfg_err), 0);
    // R5: saturated bucket admits exactly its burst, then nothing
    repeat (10) do_tick();
    send(0, 200, "R5 full burst");
    send(0, 1, "R5 empty");
    // R6: drain parent, green still passes
    for (int k = 0; k < 8; k++) send(2, 90, "R6 drain");
    sweep(400, 11);

    // scenario 2: blind parent, remark green, reserved kind on red
    base_cfg(0, 101);
    akind = '{2, 0, 3}; ama = '{1, 0, 6}; amb = '{2, 0, 7};
    do_reset();
    repeat (2) @(posedge clk); #1;
    check("R10 cfg ok at sum+1", int'(cfg_err), 0);
    for (int k = 0; k < 8; k++) send(2, 90, "R7 drain");
    sweep(400, 29);

    // scenario 3: configuration error boundary
    base_cfg(1, 100);
    do_reset();
    repeat (2) @(posedge clk); #1;
    check("R10 cfg err at sum", int'(cfg_err), 1);
    base_cfg(1, 60);
    do_reset();
    repeat (2) @(posedge clk); #1;
    check("R10 cfg err below sum", int'(cfg_err), 1);
    sweep(200, 47);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule